// File: doc/BRIEF.md
# Side-band SEC-DED Memory Data Protection Path

This block guards a 64-bit memory data path with a single-error-correcting, double-error-detecting code. The write side turns each data word into a 72-bit codeword: the data together with 8 check bits, both sent on a widened bus in the same transfer, so no extra command is needed. The read side takes a 72-bit codeword and recomputes the check bits from the received data. It compares them with the received check bits and, in the same cycle, returns corrected data with a correctable or uncorrectable flag.

A registered reporting stage sits behind the read decoder. On each accepted read it keeps a saturating count of corrected errors and a sticky uncorrectable flag. It also captures the syndrome, the request address and the kind of the first error it sees. A level interrupt follows the sticky flag and is gated by an enable input. A single clear strobe, driven by a software write-one-to-clear, wipes all the recorded state.

Top module: `ecc_sideband_path`

## Requirements
- R1: `wr_code[63:0]` equals `wr_data` and `wr_code[71:64]` holds the check bits. Check bit j is the XOR of the data bits i whose column has bit j set. The column of data bit i is the i-th 8-bit value, in ascending order, among the values whose weight is odd and at least 3.
- R2: The syndrome is the recomputed check bits XOR `rd_code[71:64]`. A zero syndrome returns `rd_code[63:0]` unchanged on `rd_data` with both flags low.
- R3: A syndrome equal to the column of data bit i returns the data with bit i inverted and raises `rd_corr` only.
- R4: A syndrome of weight one marks an error in a check bit. It raises `rd_corr` only and returns `rd_code[63:0]` unchanged.
- R5: Any other nonzero syndrome raises `rd_uncorr` only and returns the data uncorrected. This covers every even-weight syndrome and every odd-weight syndrome that matches no column. `rd_corr` and `rd_uncorr` are never high together.
- R6: `ce_count` increments by one on the clock edge that accepts a correctable read (`rd_valid` high). It saturates at all ones.
- R7: `ue_flag` sets on the clock edge that accepts an uncorrectable read and stays set until cleared.
- R8: The first accepted error of either kind sets `log_valid` and captures `log_syndrome`, `log_addr` and `log_is_ue` (1 for uncorrectable). Later errors leave these unchanged until a clear.
- R9: `irq` is high exactly while `ue_flag` and `irq_en` are both high, and `irq_en` takes effect without a clock edge.
- R10: `log_clear` high at a clock edge zeroes `ce_count`, `ue_flag`, `log_valid`, `log_is_ue`, `log_syndrome` and `log_addr`. An error presented on that same edge is dropped.
- R11: After reset all recorded state and `irq` are zero. A read with `rd_valid` low changes no recorded state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the reporting stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_data | input | 64 | Write data word |
| wr_code | output | 72 | Encoded write codeword, check bits on top |
| rd_valid | input | 1 | Read codeword is valid this cycle |
| rd_addr | input | 32 | Request address of the read |
| rd_code | input | 72 | Received read codeword |
| rd_data | output | 64 | Corrected read data (combinational) |
| rd_corr | output | 1 | Read had a correctable error |
| rd_uncorr | output | 1 | Read had an uncorrectable error |
| irq_en | input | 1 | Interrupt enable |
| log_clear | input | 1 | Write-one-to-clear strobe for recorded state |
| ce_count | output | 8 | Saturating corrected-error count |
| ue_flag | output | 1 | Sticky uncorrectable-error flag |
| log_valid | output | 1 | A first error has been captured |
| log_is_ue | output | 1 | Captured error was uncorrectable |
| log_syndrome | output | 8 | Syndrome of the first error |
| log_addr | output | 32 | Address of the first error |
| irq | output | 1 | Level interrupt |

## Verification
The assertions check several properties on every cycle:
- the two read flags are mutually exclusive;
- a zero syndrome or a check-bit-only syndrome returns the data untouched;
- the counter either steps by one or holds at saturation;
- the sticky flag and the captured log hold until a clear;
- a clear empties the state on the next edge;
- an idle read leaves the state as it was.

Other behaviour depends on concrete values that only the bench's scenarios can show. Examples are the exact check-bit values for chosen data patterns, which data bit gets flipped back for a given single error, and the syndrome and address captured from the first error in a sequence. The same holds for the count after a long run of corrected reads, and for a clear winning over an error on the same edge.

// File: rtl/ecc_pkg.sv
package ecc_pkg;

   typedef enum logic [1:0] {
      ERR_NONE   = 2'd0,
      ERR_CORR   = 2'd1,
      ERR_UNCORR = 2'd2
   } err_kind_e;

   // weight of a small integer value
   function automatic int bit_weight(input int value, input int nbits);
      int w;
      w = 0;
      for (int b = 0; b < nbits; b++) w += (value >> b) & 1;
      return w;
   endfunction

   // column of data bit idx: idx-th ascending value of odd weight >= 3
   function automatic int hsiao_col(input int idx, input int chk_w);
      int n;
      n = 0;
      for (int v = 0; v < (1 << chk_w); v++) begin
         if ((bit_weight(v, chk_w) % 2 == 1) && (bit_weight(v, chk_w) >= 3)) begin
            if (n == idx) return v;
            n++;
         end
      end
      return 0;
   endfunction

   // how many data columns a given check width can supply
   function automatic int odd_col_count(input int chk_w);
      int n;
      n = 0;
      for (int v = 0; v < (1 << chk_w); v++)
         if ((bit_weight(v, chk_w) % 2 == 1) && (bit_weight(v, chk_w) >= 3)) n++;
      return n;
   endfunction

endpackage

// File: rtl/ecc_secded_enc.sv
module ecc_secded_enc #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8
) (
   input  logic [DATA_W-1:0] data_i,
   output logic [CHK_W-1:0]  chk_o
);

   // data bits that feed check bit j
   function automatic logic [DATA_W-1:0] row_mask(input int j);
      logic [DATA_W-1:0] m;
      m = '0;
      for (int i = 0; i < DATA_W; i++)
         m[i] = ((ecc_pkg::hsiao_col(i, CHK_W) >> j) & 1) != 0;
      return m;
   endfunction

   if (CHK_W < 4 || CHK_W > 12) begin : g_bad_chk
      $error("ecc_secded_enc: CHK_W out of supported range");
   end
   if (DATA_W > ecc_pkg::odd_col_count(CHK_W)) begin : g_bad_data
      $error("ecc_secded_enc: DATA_W exceeds available odd-weight columns");
   end

   for (genvar j = 0; j < CHK_W; j++) begin : g_row
      localparam logic [DATA_W-1:0] MASK = row_mask(j);
      assign chk_o[j] = ^(data_i & MASK);
   end

endmodule

// File: rtl/ecc_secded_dec.sv
module ecc_secded_dec #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8
) (
   input  logic [DATA_W+CHK_W-1:0] code_i,
   output logic [DATA_W-1:0]       data_o,
   output logic [CHK_W-1:0]        syn_o,
   output ecc_pkg::err_kind_e      kind_o
);

   localparam int CW = DATA_W + CHK_W;

   logic [DATA_W-1:0] data_in;
   logic [CHK_W-1:0]  chk_in;
   logic [CHK_W-1:0]  chk_calc;
   logic [CHK_W-1:0]  syn;
   logic [DATA_W-1:0] hit;
   logic              chk_only;

   assign data_in = code_i[DATA_W-1:0];
   assign chk_in  = code_i[CW-1:DATA_W];

   ecc_secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_recalc (
      .data_i (data_in),
      .chk_o  (chk_calc)
   );

   assign syn   = chk_calc ^ chk_in;
   assign syn_o = syn;

   for (genvar i = 0; i < DATA_W; i++) begin : g_col
      localparam logic [CHK_W-1:0] COL = CHK_W'(ecc_pkg::hsiao_col(i, CHK_W));
      assign hit[i] = (syn == COL);
   end

   assign chk_only = ($countones(syn) == 1);

   always_comb begin
      data_o = data_in ^ hit;
      if (syn == '0)               kind_o = ecc_pkg::ERR_NONE;
      else if (|hit || chk_only)   kind_o = ecc_pkg::ERR_CORR;
      else                         kind_o = ecc_pkg::ERR_UNCORR;
   end

   always_comb begin
      AST_ZERO_SYN_PASS: assert (syn != '0 || data_o == data_in) else $error("zero syndrome altered data"); // R2
      AST_CHK_ERR_KEEPS_DATA: assert (!chk_only || data_o == data_in) else $error("check-bit error altered data"); // R4
      AST_ONE_FLIP_MAX: assert ($countones(data_o ^ data_in) <= 1) else $error("more than one bit corrected"); // R3
      AST_UNCORR_NO_FIX: assert (kind_o != ecc_pkg::ERR_UNCORR || data_o == data_in) else $error("uncorrectable data modified"); // R5
   end

endmodule

// File: rtl/ecc_err_log.sv
module ecc_err_log #(
   parameter int ADDR_W = 32,
   parameter int CHK_W  = 8,
   parameter int CNT_W  = 8
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               ev_valid_i,
   input  ecc_pkg::err_kind_e kind_i,
   input  logic [CHK_W-1:0]   syn_i,
   input  logic [ADDR_W-1:0]  addr_i,
   input  logic               irq_en_i,
   input  logic               clr_i,
   output logic [CNT_W-1:0]   cnt_o,
   output logic               ue_o,
   output logic               log_v_o,
   output logic               log_ue_o,
   output logic [CHK_W-1:0]   log_syn_o,
   output logic [ADDR_W-1:0]  log_addr_o,
   output logic               irq_o
);

   localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

   if (CNT_W < 1 || ADDR_W < 1) begin : g_bad_w
      $error("ecc_err_log: widths must be positive");
   end

   logic [CNT_W-1:0]  cnt_q;
   logic              ue_q;
   logic              log_v_q;
   logic              log_ue_q;
   logic [CHK_W-1:0]  log_syn_q;
   logic [ADDR_W-1:0] log_addr_q;
   logic              is_err;

   assign is_err = ev_valid_i && (kind_i != ecc_pkg::ERR_NONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q      <= '0;
         ue_q       <= 1'b0;
         log_v_q    <= 1'b0;
         log_ue_q   <= 1'b0;
         log_syn_q  <= '0;
         log_addr_q <= '0;
      end else if (clr_i) begin
         cnt_q      <= '0;
         ue_q       <= 1'b0;
         log_v_q    <= 1'b0;
         log_ue_q   <= 1'b0;
         log_syn_q  <= '0;
         log_addr_q <= '0;
      end else if (is_err) begin
         if (kind_i == ecc_pkg::ERR_CORR && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
         if (kind_i == ecc_pkg::ERR_UNCORR) ue_q <= 1'b1;
         if (!log_v_q) begin
            log_v_q    <= 1'b1;
            log_ue_q   <= (kind_i == ecc_pkg::ERR_UNCORR);
            log_syn_q  <= syn_i;
            log_addr_q <= addr_i;
         end
      end
   end

   assign cnt_o      = cnt_q;
   assign ue_o       = ue_q;
   assign log_v_o    = log_v_q;
   assign log_ue_o   = log_ue_q;
   assign log_syn_o  = log_syn_q;
   assign log_addr_o = log_addr_q;
   assign irq_o      = ue_q && irq_en_i;

   AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid_i && kind_i == ecc_pkg::ERR_CORR && !clr_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + 1'b1) else $error("count did not step"); // R6
   AST_CNT_SATURATE: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid_i && kind_i == ecc_pkg::ERR_CORR && !clr_i && cnt_q == CNT_MAX) |=> cnt_q == CNT_MAX) else $error("count wrapped"); // R6
   AST_UE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (ue_q && !clr_i) |=> ue_q) else $error("uncorrectable flag dropped"); // R7
   AST_UE_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid_i && kind_i == ecc_pkg::ERR_UNCORR && !clr_i) |=> ue_q) else $error("uncorrectable flag not set"); // R7
   AST_LOG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (log_v_q && !clr_i) |=> (log_v_q && $stable(log_syn_q) && $stable(log_addr_q) && $stable(log_ue_q))) else $error("log overwritten"); // R8
   AST_IRQ_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
      (ev_valid_i && kind_i == ecc_pkg::ERR_UNCORR && !clr_i && irq_en_i) |=> irq_o) else $error("interrupt missing"); // R9
   AST_CLEAR_ALL: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0 && !ue_q && !log_v_q)) else $error("clear incomplete"); // R10
   AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!ev_valid_i && !clr_i) |=> ($stable(cnt_q) && $stable(ue_q) && $stable(log_v_q))) else $error("idle read changed state"); // R11

endmodule

// File: rtl/ecc_sideband_path.sv
module ecc_sideband_path #(
   parameter int DATA_W = 64,
   parameter int CHK_W  = 8,
   parameter int ADDR_W = 32,
   parameter int CNT_W  = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [DATA_W-1:0]       wr_data,
   output logic [DATA_W+CHK_W-1:0] wr_code,
   input  logic                    rd_valid,
   input  logic [ADDR_W-1:0]       rd_addr,
   input  logic [DATA_W+CHK_W-1:0] rd_code,
   output logic [DATA_W-1:0]       rd_data,
   output logic                    rd_corr,
   output logic                    rd_uncorr,
   input  logic                    irq_en,
   input  logic                    log_clear,
   output logic [CNT_W-1:0]        ce_count,
   output logic                    ue_flag,
   output logic                    log_valid,
   output logic                    log_is_ue,
   output logic [CHK_W-1:0]        log_syndrome,
   output logic [ADDR_W-1:0]       log_addr,
   output logic                    irq
);

   logic [CHK_W-1:0]   wr_chk;
   logic [CHK_W-1:0]   rd_syn;
   ecc_pkg::err_kind_e rd_kind;

   ecc_secded_enc #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_wr_enc (
      .data_i (wr_data),
      .chk_o  (wr_chk)
   );

   assign wr_code = {wr_chk, wr_data};

   ecc_secded_dec #(.DATA_W(DATA_W), .CHK_W(CHK_W)) u_rd_dec (
      .code_i (rd_code),
      .data_o (rd_data),
      .syn_o  (rd_syn),
      .kind_o (rd_kind)
   );

   assign rd_corr   = (rd_kind == ecc_pkg::ERR_CORR);
   assign rd_uncorr = (rd_kind == ecc_pkg::ERR_UNCORR);

   always_comb begin
      AST_FLAGS_EXCLUSIVE: assert (!(rd_corr && rd_uncorr)) else $error("both read flags high"); // R5
   end

   ecc_err_log #(.ADDR_W(ADDR_W), .CHK_W(CHK_W), .CNT_W(CNT_W)) u_log (
      .clk        (clk),
      .rst_n      (rst_n),
      .ev_valid_i (rd_valid),
      .kind_i     (rd_kind),
      .syn_i      (rd_syn),
      .addr_i     (rd_addr),
      .irq_en_i   (irq_en),
      .clr_i      (log_clear),
      .cnt_o      (ce_count),
      .ue_o       (ue_flag),
      .log_v_o    (log_valid),
      .log_ue_o   (log_is_ue),
      .log_syn_o  (log_syndrome),
      .log_addr_o (log_addr),
      .irq_o      (irq)
   );

endmodule

// File: tb/ecc_sideband_path_test.sv
`timescale 1ns/1ps
module ecc_sideband_path_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [63:0] wr_data = '0;
   logic [71:0] wr_code;
   logic        rd_valid = 1'b0;
   logic [31:0] rd_addr = '0;
   logic [71:0] rd_code = '0;
   logic [63:0] rd_data;
   logic        rd_corr, rd_uncorr;
   logic        irq_en = 1'b0;
   logic        log_clear = 1'b0;
   logic [7:0]  ce_count;
   logic        ue_flag, log_valid, log_is_ue, irq;
   logic [7:0]  log_syndrome;
   logic [31:0] log_addr;

   always #2 clk = ~clk;

   ecc_sideband_path uut (
      .clk(clk), .rst_n(rst_n), .wr_data(wr_data), .wr_code(wr_code),
      .rd_valid(rd_valid), .rd_addr(rd_addr), .rd_code(rd_code),
      .rd_data(rd_data), .rd_corr(rd_corr), .rd_uncorr(rd_uncorr),
      .irq_en(irq_en), .log_clear(log_clear), .ce_count(ce_count),
      .ue_flag(ue_flag), .log_valid(log_valid), .log_is_ue(log_is_ue),
      .log_syndrome(log_syndrome), .log_addr(log_addr), .irq(irq)
   );

   typedef struct {
      logic [63:0] d;
      logic        c;
      logic        u;
      string       tag;
   } exp_t;

   exp_t        q[$];
   logic [7:0]  cols [64];
   int          n_chk = 0;
   int          n_fail = 0;
   bit          ended = 1'b0;

   // columns as the requirement states them
   initial begin
      int n;
      n = 0;
      for (int v = 0; v < 256; v++) begin
         if (($countones(8'(v)) % 2 == 1) && ($countones(8'(v)) >= 3) && n < 64) begin
            cols[n] = 8'(v);
            n++;
         end
      end
   end

   function automatic logic [7:0] mchk(input logic [63:0] d);
      logic [7:0] c;
      c = '0;
      for (int i = 0; i < 64; i++) if (d[i]) c ^= cols[i];
      return c;
   endfunction

   function automatic logic [71:0] mk(input logic [63:0] d);
      return {mchk(d), d};
   endfunction

   task automatic check(input bit ok, input string req, input string what,
                        input logic [71:0] act, input logic [71:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      if (!ended) begin
         ended = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   // driver: presents one read and pushes its expected result
   task automatic send(input logic [71:0] code, input logic [31:0] addr, input string tag);
      exp_t       e;
      logic [7:0] syn;
      syn   = mchk(code[63:0]) ^ code[71:64];
      e.d   = code[63:0];
      e.c   = 1'b0;
      e.u   = 1'b0;
      e.tag = tag;
      if (syn != '0) begin
         if ($countones(syn) == 1) e.c = 1'b1;
         else begin
            e.u = 1'b1;
            for (int i = 0; i < 64; i++)
               if (cols[i] == syn) begin
                  e.d[i] = ~e.d[i];
                  e.c = 1'b1;
                  e.u = 1'b0;
               end
         end
      end
      @(negedge clk);
      rd_valid = 1'b1;
      rd_code  = code;
      rd_addr  = addr;
      q.push_back(e);
   endtask

   task automatic idle();
      @(negedge clk);
      rd_valid = 1'b0;
      #1;
   endtask

   // monitor: compares read outputs with the scoreboard
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         #1;
         if (q.size() != 0) begin
            e = q.pop_front();
            check(rd_data == e.d, e.tag, "rd_data", {8'h0, rd_data}, {8'h0, e.d});
            check(rd_corr == e.c && rd_uncorr == e.u, e.tag, "flags",
                  {70'h0, rd_corr, rd_uncorr}, {70'h0, e.c, e.u});
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      logic [63:0] pat [4];
      logic [63:0] base;
      logic [71:0] cw;
      pat[0] = 64'h0;
      pat[1] = '1;
      pat[2] = 64'h0123_4567_89AB_CDEF;
      pat[3] = 64'h8000_0000_0000_0000;
      base   = 64'hDEAD_BEEF_CAFE_F00D;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R11 reset state
      check(ce_count == 0 && !ue_flag && !log_valid && !irq && !log_is_ue, "R11", "reset state",
            {63'h0, ce_count, ue_flag}, 72'h0);

      // R1 encoder on several patterns
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         wr_data = pat[k];
         #1;
         check(wr_code == mk(pat[k]), "R1", "wr_code", wr_code, mk(pat[k]));
      end

      // R2 clean reads
      send(mk(base), 32'h10, "R2");
      send(mk(pat[2]), 32'h14, "R2");
      send(mk(pat[1]), 32'h18, "R2");
      // R3 single data-bit errors, first one is the logged event
      cw = mk(base); cw[0]  = ~cw[0];  send(cw, 32'h1000, "R3");
      cw = mk(base); cw[37] = ~cw[37]; send(cw, 32'h1004, "R3");
      cw = mk(base); cw[63] = ~cw[63]; send(cw, 32'h1008, "R3");
      // R4 check-bit errors
      cw = mk(base); cw[64] = ~cw[64]; send(cw, 32'h100C, "R4");
      cw = mk(base); cw[71] = ~cw[71]; send(cw, 32'h1010, "R4");
      idle();
      check(ce_count == 8'd5, "R6", "ce_count after 5", {64'h0, ce_count}, 72'd5);
      check(log_valid && !log_is_ue && log_syndrome == cols[0] && log_addr == 32'h1000,
            "R8", "first capture", {31'h0, log_valid, log_is_ue, log_syndrome, log_addr},
            {31'h0, 1'b1, 1'b0, cols[0], 32'h1000});
      check(!ue_flag, "R7", "no ue yet", {71'h0, ue_flag}, 72'h0);

      // R5 double errors, interrupt disabled
      cw = mk(base); cw[3] = ~cw[3]; cw[40] = ~cw[40]; send(cw, 32'h2000, "R5");
      cw = mk(pat[2]); cw[5] = ~cw[5]; cw[66] = ~cw[66]; send(cw, 32'h2004, "R5");
      idle();
      check(ue_flag, "R7", "ue_flag set", {71'h0, ue_flag}, 72'h1);
      check(!irq, "R9", "irq gated off", {71'h0, irq}, 72'h0);
      check(log_syndrome == cols[0] && log_addr == 32'h1000 && !log_is_ue, "R8", "log held",
            {32'h0, log_syndrome, log_addr}, {32'h0, cols[0], 32'h1000});
      check(ce_count == 8'd5, "R6", "ue does not count", {64'h0, ce_count}, 72'd5);

      // R9 enable without a clock edge
      @(negedge clk);
      irq_en = 1'b1;
      #1;
      check(irq, "R9", "irq level", {71'h0, irq}, 72'h1);

      // R11 idle read with an error on the bus
      @(negedge clk);
      rd_valid = 1'b0;
      cw = mk(base); cw[9] = ~cw[9];
      rd_code = cw;
      @(negedge clk);
      #1;
      check(ce_count == 8'd5, "R11", "invalid read ignored", {64'h0, ce_count}, 72'd5);

      // R10 clear wins over a same-edge error
      @(negedge clk);
      log_clear = 1'b1;
      rd_valid  = 1'b1;
      cw = mk(base); cw[12] = ~cw[12];
      rd_code = cw;
      @(negedge clk);
      log_clear = 1'b0;
      rd_valid  = 1'b0;
      #1;
      check(ce_count == 0 && !ue_flag && !log_valid && !irq, "R10", "clear",
            {62'h0, ce_count, ue_flag, log_valid}, 72'h0);

      // R6 saturation over 300 corrected reads
      for (int k = 0; k < 300; k++) begin
         cw = mk(base ^ 64'(k));
         cw[k % 64] = ~cw[k % 64];
         send(cw, 32'h3000 + 32'(k), "R3");
      end
      idle();
      check(ce_count == 8'hFF, "R6", "saturation", {64'h0, ce_count}, 72'hFF);
      check(log_valid && log_syndrome == cols[0] && log_addr == 32'h3000, "R8", "capture after clear",
            {31'h0, log_valid, 8'h0, log_syndrome, log_addr}, {31'h0, 1'b1, 8'h0, cols[0], 32'h3000});

      repeat (2) @(negedge clk);
      finish_run();
   end

endmodule